// File: doc/BRIEF.md
# USB Device Interrupt Router

This block gathers per-endpoint completion events from a USB device core and presents them as two interrupt request lines, one high priority and one low priority. Each physical endpoint direction has one sticky bit in a 32-bit endpoint status word. An OUT endpoint sets its bit when it receives a packet without error. An IN endpoint sets its bit when it sends a packet successfully, or when it answers with a NAK while interrupt-on-NAK is enabled. Endpoints that the core declares isochronous never set status bits. Their data is serviced on the frame interrupt instead.

The set status bits are split by a per-endpoint priority mask into a fast summary and a slow summary. A start-of-frame strobe sets a sticky frame flag. A two-bit device priority register can send either the frame interrupt or the fast summary to the high-priority line. If software asks for both at once, neither goes there and both fall back to the low-priority line. Software reaches all of this through a small register bus. Writes are synchronous and reads are combinational.

Top module: `usb_irq_router`

## Requirements
- R1: After synchronous reset, the endpoint status word, the endpoint priority mask, the device priority bits and the frame flag are all zero, and `irq_hp` and `irq_lp` are both low.
- R2: A pulse on `ep_rx_ok[n]` sets status bit 2n, and a pulse on `ep_tx_ok[n]` sets status bit 2n+1. The bit is visible at address 0 after the next rising clock edge and stays set.
- R3: A pulse on `ep_tx_nak[n]` sets status bit 2n+1 only while `nak_int_en` is 1. With `nak_int_en` at 0 it changes nothing.
- R4: While `iso_ep[n]` is 1, no event can set status bits 2n or 2n+1. Other endpoints are unaffected.
- R5: Writing address 1 clears every status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. If an event for a bit arrives in the same cycle as its clear, the bit stays set.
- R6: Address 2 is a read/write endpoint priority mask. Address 4 reads {slow, fast, frame} in bits 2..0. Here fast is 1 when a set status bit has mask bit 1, and slow is 1 when a set status bit has mask bit 0.
- R7: `sof` sets the frame flag. Writing address 5 with bit 0 set clears it, unless `sof` arrives in the same cycle, in which case the flag stays set.
- R8: Address 3 is the write-only device priority register: bit 0 routes the frame flag and bit 1 routes the fast summary to `irq_hp`. Reading address 3 returns 0.
- R9: When both device priority bits are 1, `irq_hp` is low regardless of the summaries.
- R10: `irq_lp` is high when the slow summary is set, or when the frame flag or the fast summary is set and is not routed to `irq_hp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ep_rx_ok | input | 16 | Per-endpoint OUT packet received without error |
| ep_tx_ok | input | 16 | Per-endpoint IN packet sent successfully |
| ep_tx_nak | input | 16 | Per-endpoint IN NAK handshake sent |
| nak_int_en | input | 1 | Enables NAK events as interrupt sources |
| iso_ep | input | 16 | Per-endpoint isochronous marker, masks events |
| sof | input | 1 | Start-of-frame strobe |
| irq_hp | output | 1 | High-priority interrupt request |
| irq_lp | output | 1 | Low-priority interrupt request |

## Verification
The routing function is tried with every device priority setting against single, paired and absent frame, fast and slow sources. These cases separate the correct routing from a swapped bit assignment, a missing exclusion rule and a low line that ignores unrouted summaries. Directed cases place events on the lowest and highest endpoints so that bit-position errors show up. They drive a clear and an event into the same bit in the same cycle to show which one wins. They gate NAK and isochronous events by their configuration inputs. They also race a frame clear against a start-of-frame strobe.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    typedef enum logic [2:0] {
        REG_EP_STAT  = 3'd0,
        REG_EP_CLR   = 3'd1,
        REG_EP_PRI   = 3'd2,
        REG_DEV_PRI  = 3'd3,
        REG_DEV_STAT = 3'd4,
        REG_DEV_CLR  = 3'd5
    } reg_addr_e;

    // Device-level summary, frame in bit 0
    typedef struct packed {
        logic slow;
        logic fast;
        logic frame;
    } dev_sum_t;

    typedef struct packed {
        logic hp;
        logic lp;
    } irq_pair_t;

    localparam int DEV_SUM_W = $bits(dev_sum_t);

    // Frame or fast may go high, never both
    function automatic irq_pair_t route_irqs(dev_sum_t s, logic [1:0] pri);
        irq_pair_t r;
        logic frame_up;
        logic fast_up;
        frame_up = pri[0] & ~pri[1];
        fast_up  = pri[1] & ~pri[0];
        r.hp = (s.frame & frame_up) | (s.fast & fast_up);
        r.lp = s.slow | (s.frame & ~frame_up) | (s.fast & ~fast_up);
        return r;
    endfunction

endpackage

// File: rtl/usb_irq_ep_status.sv
module usb_irq_ep_status #(
    parameter int NUM_EP = 16,
    localparam int BITS  = 2 * NUM_EP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EP-1:0] rx_ok,
    input  logic [NUM_EP-1:0] tx_ok,
    input  logic [NUM_EP-1:0] tx_nak,
    input  logic              nak_int_en,
    input  logic [NUM_EP-1:0] iso_ep,
    input  logic              clr_we,
    input  logic [BITS-1:0]   clr_bits,
    output logic [BITS-1:0]   status
);

    logic [BITS-1:0] ev;
    logic [BITS-1:0] iso_phys;
    logic [BITS-1:0] clr_eff;

    for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
        assign ev[2*n]         = rx_ok[n] & ~iso_ep[n];
        assign ev[2*n+1]       = (tx_ok[n] | (tx_nak[n] & nak_int_en)) & ~iso_ep[n];
        assign iso_phys[2*n]   = iso_ep[n];
        assign iso_phys[2*n+1] = iso_ep[n];
    end

    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | ev;
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

    assert_iso_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & $past(iso_phys)) == '0));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((status & $past(clr_bits & ~ev)) == '0));

endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int BITS  = 2 * NUM_EP
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [2:0]      addr,
    input  logic [BITS-1:0] wdata,
    input  logic            sof,
    output logic [BITS-1:0] ep_pri,
    output logic [1:0]      dev_pri,
    output logic            frame_flag
);

    logic frame_clr;
    assign frame_clr = we && (addr == REG_DEV_CLR) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_pri     <= '0;
            dev_pri    <= '0;
            frame_flag <= 1'b0;
        end else begin
            if (we && addr == REG_EP_PRI)  ep_pri  <= wdata;
            if (we && addr == REG_DEV_PRI) dev_pri <= wdata[1:0];
            if (sof)            frame_flag <= 1'b1;
            else if (frame_clr) frame_flag <= 1'b0;
        end
    end

    assert_sof_sets_frame_R7: assert property (@(posedge clk) disable iff (rst)
        sof |=> frame_flag);

    assert_frame_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_flag && !frame_clr) |=> frame_flag);

endmodule

// File: rtl/usb_irq_route.sv
module usb_irq_route
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int BITS  = 2 * NUM_EP
) (
    input  logic [BITS-1:0] status,
    input  logic [BITS-1:0] ep_pri,
    input  logic            frame_flag,
    input  logic [1:0]      dev_pri,
    output dev_sum_t        sum,
    output logic            irq_hp,
    output logic            irq_lp
);

    irq_pair_t pair;

    always_comb begin
        sum.frame = frame_flag;
        sum.fast  = |(status & ep_pri);
        sum.slow  = |(status & ~ep_pri);
        pair      = route_irqs(sum, dev_pri);
    end

    assign irq_hp = pair.hp;
    assign irq_lp = pair.lp;

endmodule

// File: rtl/usb_irq_router.sv
module usb_irq_router
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int BITS  = 2 * NUM_EP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BITS-1:0]   bus_wdata,
    output logic [BITS-1:0]   bus_rdata,
    input  logic [NUM_EP-1:0] ep_rx_ok,
    input  logic [NUM_EP-1:0] ep_tx_ok,
    input  logic [NUM_EP-1:0] ep_tx_nak,
    input  logic              nak_int_en,
    input  logic [NUM_EP-1:0] iso_ep,
    input  logic              sof,
    output logic              irq_hp,
    output logic              irq_lp
);

    logic [BITS-1:0] status;
    logic [BITS-1:0] ep_pri;
    logic [1:0]      dev_pri;
    logic            frame_flag;
    dev_sum_t        sum;

    usb_irq_ep_status #(.NUM_EP(NUM_EP)) u_status (
        .clk        (clk),
        .rst        (rst),
        .rx_ok      (ep_rx_ok),
        .tx_ok      (ep_tx_ok),
        .tx_nak     (ep_tx_nak),
        .nak_int_en (nak_int_en),
        .iso_ep     (iso_ep),
        .clr_we     (bus_wr && bus_addr == REG_EP_CLR),
        .clr_bits   (bus_wdata),
        .status     (status)
    );

    usb_irq_regs #(.NUM_EP(NUM_EP)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .sof        (sof),
        .ep_pri     (ep_pri),
        .dev_pri    (dev_pri),
        .frame_flag (frame_flag)
    );

    usb_irq_route #(.NUM_EP(NUM_EP)) u_route (
        .status     (status),
        .ep_pri     (ep_pri),
        .frame_flag (frame_flag),
        .dev_pri    (dev_pri),
        .sum        (sum),
        .irq_hp     (irq_hp),
        .irq_lp     (irq_lp)
    );

    always_comb begin
        case (bus_addr)
            REG_EP_STAT:  bus_rdata = status;
            REG_EP_PRI:   bus_rdata = ep_pri;
            REG_DEV_STAT: bus_rdata = {{(BITS-DEV_SUM_W){1'b0}}, sum};
            default:      bus_rdata = '0;
        endcase
    end

    assert_hp_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        (dev_pri == 2'b11) |-> !irq_hp);

    assert_slow_goes_low_R10: assert property (@(posedge clk) disable iff (rst)
        (sum.slow) |-> irq_lp);

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0 && !irq_hp && !irq_lp));

endmodule

// File: tb/test_usb_irq_router.sv
module test_usb_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] ep_rx_ok = '0;
    logic [15:0] ep_tx_ok = '0;
    logic [15:0] ep_tx_nak = '0;
    logic        nak_int_en = 1'b0;
    logic [15:0] iso_ep = '0;
    logic        sof = 1'b0;
    logic        irq_hp;
    logic        irq_lp;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    usb_irq_router i_usb_irq_router (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ep_rx_ok(ep_rx_ok), .ep_tx_ok(ep_tx_ok), .ep_tx_nak(ep_tx_nak),
        .nak_int_en(nak_int_en), .iso_ep(iso_ep), .sof(sof),
        .irq_hp(irq_hp), .irq_lp(irq_lp)
    );

    // {pri[1:0], frame, fast, slow, exp_hp, exp_lp}
    localparam logic [6:0] VEC [12] = '{
        7'b00_100_01, 7'b01_100_10, 7'b10_100_01, 7'b10_010_10,
        7'b01_010_01, 7'b11_100_01, 7'b11_010_01, 7'b11_110_01,
        7'b01_110_11, 7'b10_011_11, 7'b00_000_00, 7'b01_001_01
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input logic [15:0] rx, input logic [15:0] tx,
                         input logic [15:0] nak, input logic s);
        @(negedge clk);
        ep_rx_ok = rx; ep_tx_ok = tx; ep_tx_nak = nak; sof = s;
        @(negedge clk);
        ep_rx_ok = '0; ep_tx_ok = '0; ep_tx_nak = '0; sof = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd5, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 32'h0);
        rd(3'd2, v); chk("R1 mask", v, 32'h0);
        rd(3'd4, v); chk("R1 dev summary", v, 32'h0);
        chk("R1 irqs", {30'b0, irq_hp, irq_lp}, 32'h0);

        // Routing table: R8 R9 R10 R6
        wr(3'd2, 32'h0000_0001);
        rd(3'd2, v); chk("R6 mask readback", v, 32'h1);
        for (int i = 0; i < 12; i++) begin
            clear_all();
            wr(3'd3, {30'b0, VEC[i][6:5]});
            pulse({14'b0, VEC[i][2], VEC[i][3]}, '0, '0, VEC[i][4]);
            chk($sformatf("R8/R9/R10 vec %0d hp", i), {31'b0, irq_hp}, {31'b0, VEC[i][1]});
            chk($sformatf("R8/R9/R10 vec %0d lp", i), {31'b0, irq_lp}, {31'b0, VEC[i][0]});
            if (i == 9) begin
                rd(3'd4, v); chk("R6 summary fast+slow", v, 32'h6);
            end
        end
        rd(3'd3, v); chk("R8 write-only reads 0", v, 32'h0);

        // R2 bit positions
        clear_all();
        pulse(16'h0008, 16'h8000, '0, 1'b0);
        rd(3'd0, v); chk("R2 rx ep3 / tx ep15", v, 32'h8000_0040);

        // R5 event beats clear, zero bits ignored, one bits clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h8000_0040; ep_rx_ok = 16'h0008;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; ep_rx_ok = '0;
        rd(3'd0, v); chk("R5 event wins over clear", v, 32'h0000_0040);
        wr(3'd1, 32'h0);
        rd(3'd0, v); chk("R5 zero clear no effect", v, 32'h0000_0040);
        wr(3'd1, 32'h0000_0040);
        rd(3'd0, v); chk("R5 clear", v, 32'h0);

        // R3 NAK gating
        nak_int_en = 1'b0;
        pulse('0, '0, 16'h0004, 1'b0);
        rd(3'd0, v); chk("R3 nak disabled", v, 32'h0);
        nak_int_en = 1'b1;
        pulse('0, '0, 16'h0004, 1'b0);
        rd(3'd0, v); chk("R3 nak enabled", v, 32'h0000_0020);
        nak_int_en = 1'b0;

        // R4 isochronous masking
        clear_all();
        iso_ep = 16'h0010;
        pulse(16'h0030, 16'h0010, '0, 1'b0);
        rd(3'd0, v); chk("R4 iso ep4 blocked, ep5 set", v, 32'h0000_0400);
        iso_ep = '0;

        // R7 frame flag
        clear_all();
        pulse('0, '0, '0, 1'b1);
        rd(3'd4, v); chk("R7 sof sets frame", v, 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h1; sof = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; sof = 1'b0;
        rd(3'd4, v); chk("R7 sof wins over clear", v, 32'h1);
        wr(3'd5, 32'h1);
        rd(3'd4, v); chk("R7 clear frame", v, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule